// File: doc/BRIEF.md
# Three-phase gate drive protection core

This block is the digital heart of a three-phase half-bridge pre-driver. Each phase has one high-side and one low-side active-high PWM request. The block turns each pair into two gate enables. It never lets both switches of a leg conduct together. It also applies three kinds of protection: an over-current flag, a main-supply undervoltage flag and a high-side supply undervoltage flag for each phase.

Every asynchronous input passes through a two-flop synchronizer. All gate enables and the fault output leave from flops, so they are glitch-free.

Over-current shuts every gate and pulls the active-low fault output down. Both stay that way for a fixed number of clock cycles after the flag clears, and then release without software action. The default hold count is 9 ms at a 250 MHz clock.

Main-supply undervoltage gates all outputs off and releases as soon as the flag clears. A high-side supply undervoltage only turns off that phase's high-side gate. That gate then stays locked until its own PWM request has been seen low. Dead time is not inserted here; the PWM source must supply it.

Top module: `phase_gate_guard`

## Requirements
- R1: For each phase, a high-side request alone enables only the high-side gate, and a low-side request alone enables only the low-side gate. A change at an input reaches the gate output on the third rising clock edge after it.
- R2: When a phase's two requests are both high or both low, both gates of that phase are off.
- R3: While the synchronized over-current flag is high, all six gates are off whatever the requests are, and the fault output (bit value 0 = fault) is low.
- R4: The fault is not latched. After the over-current input falls, the fault output returns high on exactly the HOLD_CYCLES+2-th rising edge. Gates may turn on again one edge later.
- R5: If over-current reasserts while the hold is running, the hold restarts. It then ends HOLD_CYCLES+2 edges after the last fall of the input, and the fault output stays low throughout.
- R6: Main-supply undervoltage turns all six gates off without driving the fault output. Gates follow the requests again at the same three-edge latency as soon as it clears. If it overlaps an over-current hold, the fault output still follows only the over-current hold.
- R7: A high-side supply undervoltage on one phase turns off only that phase's high-side gate. The other gates and the fault output are unaffected.
- R8: After a phase's high-side supply undervoltage clears, that high-side gate stays off until its request has been low at least once.
- R9: In and just after reset, all gates are off and the fault output is high. A high-side request held high through reset does not turn on its gate until it has first gone low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hi_pwm_i | input | N_PHASE | High-side PWM requests, bit i = phase i |
| lo_pwm_i | input | N_PHASE | Low-side PWM requests |
| oc_flag_i | input | 1 | Over-current comparator flag, active high, asynchronous |
| vmain_uv_i | input | 1 | Main-supply undervoltage flag, active high |
| hs_uv_i | input | N_PHASE | High-side supply undervoltage flags per phase |
| hi_gate_o | output | N_PHASE | High-side gate enables |
| lo_gate_o | output | N_PHASE | Low-side gate enables |
| fault_n_o | output | 1 | Fault output, low while over-current or its hold is active |

## Verification
Two functions can meet in one cycle.

The first pair is the over-current hold and the main-supply lockout. The bench raises main-supply undervoltage inside a running hold, then lets the hold expire while the undervoltage is still present. It judges that the fault output rises on the hold's own count while the gates stay off until the supply flag clears.

The second pair is the end of a high-side undervoltage and a request that is still high. Here the bench expects the gate to stay off until the request toggles low and back.

The release edge is measured by counting edges from the fall of over-current, both for a single event and for a reassertion in mid-hold.

// File: rtl/pgg_pkg.sv
package pgg_pkg;

    // Registered state of one half-bridge leg
    typedef struct packed {
        logic hi_gate;
        logic lo_gate;
        logic hs_lock;   // high-side lockout after supply undervoltage
    } leg_state_t;

endpackage

// File: rtl/pgg_sync.sv
module pgg_sync #(
    parameter int               WIDTH   = 1,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] stab_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            stab_q <= RST_VAL;
        end else begin
            meta_q <= async_i;
            stab_q <= meta_q;
        end
    end

    assign sync_o = stab_q;

endmodule

// File: rtl/pgg_hold_timer.sv
module pgg_hold_timer #(
    parameter int HOLD_CYCLES = 2250000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic oc_s,
    output logic active_o
);

    localparam int CW = $clog2(HOLD_CYCLES + 1);
    localparam logic [CW-1:0] LOAD_VAL = CW'(HOLD_CYCLES - 1);

    typedef struct packed {
        logic          active;
        logic [CW-1:0] cnt;
    } hold_t;

    hold_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (oc_s) begin
            st_d.active = 1'b1;
            st_d.cnt    = LOAD_VAL;
        end else if (st_q.active) begin
            if (st_q.cnt == '0) begin
                st_d.active = 1'b0;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign active_o = st_q.active;

endmodule

// File: rtl/pgg_leg.sv
module pgg_leg
    import pgg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hi_s,
    input  logic lo_s,
    input  logic hs_uv_s,
    input  logic kill_all,
    output logic hi_gate_o,
    output logic lo_gate_o
);

    leg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // lockout sets on undervoltage, clears only once request seen low
        if (hs_uv_s) begin
            st_d.hs_lock = 1'b1;
        end else if (!hi_s) begin
            st_d.hs_lock = 1'b0;
        end
        st_d.hi_gate = hi_s & ~lo_s & ~kill_all & ~hs_uv_s & ~st_q.hs_lock;
        st_d.lo_gate = lo_s & ~hi_s & ~kill_all;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{hi_gate: 1'b0, lo_gate: 1'b0, hs_lock: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign hi_gate_o = st_q.hi_gate;
    assign lo_gate_o = st_q.lo_gate;

endmodule

// File: rtl/phase_gate_guard.sv
module phase_gate_guard #(
    parameter int N_PHASE     = 3,
    parameter int HOLD_CYCLES = 2250000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_PHASE-1:0] hi_pwm_i,
    input  logic [N_PHASE-1:0] lo_pwm_i,
    input  logic               oc_flag_i,
    input  logic               vmain_uv_i,
    input  logic [N_PHASE-1:0] hs_uv_i,
    output logic [N_PHASE-1:0] hi_gate_o,
    output logic [N_PHASE-1:0] lo_gate_o,
    output logic               fault_n_o
);

    logic [N_PHASE-1:0] hi_s;
    logic [N_PHASE-1:0] lo_s;
    logic [N_PHASE-1:0] hs_uv_s;
    logic               oc_s;
    logic               vmain_uv_s;
    logic               hold_active;
    logic               kill_all;

    // high-side requests read as high during reset: an input held high
    // through reset must still go low once before its gate can open
    pgg_sync #(.WIDTH(N_PHASE), .RST_VAL({N_PHASE{1'b1}})) u_sync_hi (
        .clk(clk), .rst_n(rst_n), .async_i(hi_pwm_i), .sync_o(hi_s)
    );

    pgg_sync #(.WIDTH(N_PHASE), .RST_VAL('0)) u_sync_lo (
        .clk(clk), .rst_n(rst_n), .async_i(lo_pwm_i), .sync_o(lo_s)
    );

    pgg_sync #(.WIDTH(N_PHASE), .RST_VAL('0)) u_sync_hsuv (
        .clk(clk), .rst_n(rst_n), .async_i(hs_uv_i), .sync_o(hs_uv_s)
    );

    pgg_sync #(.WIDTH(2), .RST_VAL(2'b00)) u_sync_sup (
        .clk(clk), .rst_n(rst_n),
        .async_i({oc_flag_i, vmain_uv_i}),
        .sync_o({oc_s, vmain_uv_s})
    );

    pgg_hold_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
        .clk(clk), .rst_n(rst_n), .oc_s(oc_s), .active_o(hold_active)
    );

    assign kill_all  = oc_s | hold_active | vmain_uv_s;
    assign fault_n_o = ~hold_active;

    for (genvar p = 0; p < N_PHASE; p++) begin : g_leg
        pgg_leg u_leg (
            .clk      (clk),
            .rst_n    (rst_n),
            .hi_s     (hi_s[p]),
            .lo_s     (lo_s[p]),
            .hs_uv_s  (hs_uv_s[p]),
            .kill_all (kill_all),
            .hi_gate_o(hi_gate_o[p]),
            .lo_gate_o(lo_gate_o[p])
        );
    end

endmodule

// File: rtl/pgg_checker.sv
module pgg_checker #(
    parameter int N_PHASE = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               oc_s,
    input logic               vmain_uv_s,
    input logic [N_PHASE-1:0] hs_uv_s,
    input logic [N_PHASE-1:0] hi_gate_o,
    input logic [N_PHASE-1:0] lo_gate_o,
    input logic               fault_n_o
);

    // R2
    no_shoot_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_gate_o & lo_gate_o) == '0);

    // R3
    fault_gates_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fault_n_o |-> (hi_gate_o == '0 && lo_gate_o == '0));

    // R3
    oc_kills_gates_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oc_s |=> (hi_gate_o == '0 && lo_gate_o == '0));

    // R6
    fault_only_from_oc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fault_n_o) |-> $past(oc_s));

    // R4
    release_after_oc_gone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_n_o) |-> !$past(oc_s));

    // R6
    main_uv_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vmain_uv_s |=> (hi_gate_o == '0 && lo_gate_o == '0));

    // R7
    hs_uv_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|hs_uv_s) |=> ((hi_gate_o & $past(hs_uv_s)) == '0));

endmodule

bind phase_gate_guard pgg_checker #(.N_PHASE(N_PHASE)) u_pgg_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .oc_s      (oc_s),
    .vmain_uv_s(vmain_uv_s),
    .hs_uv_s   (hs_uv_s),
    .hi_gate_o (hi_gate_o),
    .lo_gate_o (lo_gate_o),
    .fault_n_o (fault_n_o)
);

// File: tb/tb_phase_gate_guard.sv
`timescale 1ns/1ps
module tb_phase_gate_guard;

    localparam int NP   = 3;
    localparam int HOLD = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] hi_pwm = '0;
    logic [NP-1:0] lo_pwm = '0;
    logic          oc = 1'b0;
    logic          vuv = 1'b0;
    logic [NP-1:0] hs_uv = '0;
    logic [NP-1:0] hi_gate;
    logic [NP-1:0] lo_gate;
    logic          fault_n;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    phase_gate_guard #(.N_PHASE(NP), .HOLD_CYCLES(HOLD)) dut (
        .clk(clk), .rst_n(rst_n), .hi_pwm_i(hi_pwm), .lo_pwm_i(lo_pwm),
        .oc_flag_i(oc), .vmain_uv_i(vuv), .hs_uv_i(hs_uv),
        .hi_gate_o(hi_gate), .lo_gate_o(lo_gate), .fault_n_o(fault_n)
    );

    // compare {fault_n, hi_gate, lo_gate}
    task automatic check(input string req, input logic [2*NP:0] exp);
        logic [2*NP:0] got;
        got = {fault_n, hi_gate, lo_gate};
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got fault_n/hi/lo=%b expected %b at %0t", req, got, exp, $time);
        end
    endtask

    task automatic check_int(input string req, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic settle();
        repeat (4) @(posedge clk);
        #1;
    endtask

    function automatic logic [2*NP:0] ideal(input logic [NP-1:0] h, input logic [NP-1:0] l);
        return {1'b1, h & ~l, l & ~h};
    endfunction

    // count edges from now until fault_n reads high
    task automatic count_release(output int n);
        n = 0;
        do begin
            @(posedge clk);
            #1;
            n++;
        end while (!fault_n && n < 1000);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: run did not finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int n;
        // R9: high-side request held high across reset
        hi_pwm = '1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R9 reset outputs", {1'b1, 3'b000, 3'b000});
        repeat (6) @(posedge clk);
        #1;
        check("R9 held-high request stays locked", {1'b1, 3'b000, 3'b000});
        @(negedge clk); hi_pwm = '0;
        settle();
        @(negedge clk); hi_pwm = '1;
        settle();
        check("R9 unlock after low", ideal(3'b111, 3'b000));

        // R1: exact latency
        @(negedge clk); hi_pwm = '0; lo_pwm = '0;
        settle();
        @(negedge clk); hi_pwm = 3'b001; lo_pwm = 3'b100;
        repeat (2) @(posedge clk);
        #1;
        check("R1 not yet at edge 2", ideal(3'b000, 3'b000));
        @(posedge clk);
        #1;
        check("R1 visible at edge 3", ideal(3'b001, 3'b100));

        // R1 / R2: full sweep of request patterns
        for (int v = 0; v < 64; v++) begin
            @(negedge clk);
            hi_pwm = v[2:0];
            lo_pwm = v[5:3];
            settle();
            check("R1/R2 sweep", ideal(v[2:0], v[5:3]));
        end

        // R3: over-current blocks every pattern
        @(negedge clk); oc = 1'b1; hi_pwm = 3'b101; lo_pwm = 3'b010;
        settle();
        check("R3 oc on", {1'b0, 3'b000, 3'b000});
        for (int v = 0; v < 64; v++) begin
            @(negedge clk);
            hi_pwm = v[2:0];
            lo_pwm = v[5:3];
            repeat (2) @(posedge clk);
            #1;
            check("R3 oc sweep", {1'b0, 3'b000, 3'b000});
        end

        // R4: release timing
        @(negedge clk); hi_pwm = 3'b001; lo_pwm = 3'b010;
        settle();
        @(negedge clk); oc = 1'b0;
        count_release(n);
        check_int("R4 release edge count", n, HOLD + 2);
        check("R4 gates still off at release", {1'b1, 3'b000, 3'b000});
        @(posedge clk);
        #1;
        check("R4 gates resume", ideal(3'b001, 3'b010));

        // R5: reassert during hold restarts it
        @(negedge clk); oc = 1'b1;
        settle();
        @(negedge clk); oc = 1'b0;
        repeat (HOLD / 2) @(posedge clk);
        #1;
        check("R5 mid-hold", {1'b0, 3'b000, 3'b000});
        @(negedge clk); oc = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk); oc = 1'b0;
        count_release(n);
        check_int("R5 restarted hold count", n, HOLD + 2);

        // R6: main-supply undervoltage
        @(negedge clk); hi_pwm = 3'b011; lo_pwm = 3'b100;
        settle();
        @(negedge clk); vuv = 1'b1;
        settle();
        check("R6 main uv off, no fault", {1'b1, 3'b000, 3'b000});
        @(negedge clk); vuv = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check("R6 immediate resume", ideal(3'b011, 3'b100));
        // R6 overlapping an over-current hold
        @(negedge clk); oc = 1'b1;
        settle();
        @(negedge clk); oc = 1'b0; vuv = 1'b1;
        count_release(n);
        check_int("R6 hold count with uv overlap", n, HOLD + 2);
        repeat (3) @(posedge clk);
        #1;
        check("R6 uv keeps gates off after hold", {1'b1, 3'b000, 3'b000});
        @(negedge clk); vuv = 1'b0;
        settle();
        check("R6 resume after overlap", ideal(3'b011, 3'b100));

        // R7: per-phase high-side undervoltage
        @(negedge clk); hi_pwm = 3'b111; lo_pwm = 3'b000;
        settle();
        @(negedge clk); hs_uv = 3'b010;
        settle();
        check("R7 only phase1 high off", {1'b1, 3'b101, 3'b000});
        // R8: stays off after recovery while request high
        @(negedge clk); hs_uv = 3'b000;
        repeat (8) @(posedge clk);
        #1;
        check("R8 locked while request high", {1'b1, 3'b101, 3'b000});
        @(negedge clk); hi_pwm = 3'b101;
        settle();
        @(negedge clk); hi_pwm = 3'b111;
        settle();
        check("R8 unlocked after low", ideal(3'b111, 3'b000));
        // R7: low-side and other phases untouched
        @(negedge clk); hi_pwm = 3'b110; lo_pwm = 3'b001; hs_uv = 3'b001;
        settle();
        check("R7 low side kept", ideal(3'b110, 3'b001));
        @(negedge clk); hs_uv = 3'b000;
        settle();

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule